// File: doc/BRIEF.md
# Sampling Clock Control Registers

This block is the small register file that sets where a high-speed SD host samples incoming data. Software reaches it over a simple register bus with separate read and write strobes, a byte address and a 32-bit data word. The stored fields go straight to the sampling datapath: a tap enable, the selected tap position, an initial tap position, and a choice between the tuned sampling clock and the default clock.

The block also tracks re-tuning. Software sets an automatic re-tune enable. The datapath raises a one-cycle error pulse when sampling drifts, and that pulse latches a sticky error flag. The flag can always be read. It is reported upward on a dedicated output only while automatic re-tuning is enabled. Software clears the flag by writing to the request register with the flag bit at 0.

Registers are 16-bit slots on the host. The parameter `BUS_SHIFT` spaces them 2, 4 or 8 bytes apart to match the host's address stride. The tap-count field has a fixed read value, so software learns how many taps the delay line has.

Top module: `sd_sampling_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset, all of the following are 0: tap enable, tap position, initial tap position, clock select, re-tune enable, error flag, `retune_err_o` and `bus_rdata`.
- R2: Register k (k = 0..5) sits at byte address (2·k) << BUS_SHIFT. A byte address whose low BUS_SHIFT+1 bits are not zero, or whose index is 6 or more, reads as 0, and writes to it change nothing.
- R3: Register 1 (tap position) holds TAP_W bits in bits TAP_W-1:0. A write appears on `tap_sel_o` on the clock cycle after the write, and the value reads back from the same bits.
- R4: In register 0 (tap control), bit 0 is the tap enable, is read/write and drives `tap_en_o`. Bits 23:16 always read NUM_TAPS (8 by default), and writes to them are ignored. All other bits read 0.
- R5: Register 2 (initial tap position) holds TAP_W read/write bits in bits TAP_W-1:0 and drives `init_tap_o`.
- R6: In register 3 (clock select), bit 0 drives `samp_clk_sel_o`: 1 selects the tuned sampling clock and 0 selects the default clock.
- R7: In register 4 (re-tune control), bit 0 is the automatic re-tune enable and is read/write.
- R8: In register 5 (re-tune request), bit 2 is a sticky error flag that `retune_err_pulse_i` sets on the next cycle. A write with bit 2 at 0 clears the flag. A write with bit 2 at 1 leaves it unchanged. A pulse in the same cycle as a clearing write leaves the flag set.
- R9: `retune_err_o` is 1 exactly when the error flag and the re-tune enable are both set. It follows them with the same one-cycle latency. The flag stays readable while the enable is 0.
- R10: `bus_rdata` is registered. It shows the addressed register one cycle after `bus_rd` and holds between reads. A read issued in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| retune_err_pulse_i | input | 1 | One-cycle sampling error from the datapath |
| tap_en_o | output | 1 | Tap enable to the delay line |
| tap_sel_o | output | TAP_W | Selected sampling tap |
| init_tap_o | output | TAP_W | Initial tap position |
| samp_clk_sel_o | output | 1 | 1: tuned sampling clock, 0: default clock |
| retune_err_o | output | 1 | Re-tune error reported upward |

## Verification
The bench writes a data pattern to every one of the 256 byte addresses. After each write it reads back every mapped register and the swept address itself, so a decoder that ignores the low address bits or aliases past register 5 shows up as a corrupted field or a nonzero read. Directed cases target the error path: a pulse with the enable clear must stay invisible on `retune_err_o` yet readable, a flag-keeping write must not clear it, and a pulse that coincides with a clear must survive. A design that lets the clear win would silently lose an error. The tap-count field is written with ones throughout the sweep, so a design that stores those bits would read back the wrong count.

// File: rtl/sccr_pkg.sv
package sccr_pkg;
  localparam int NUM_REGS = 6;

  typedef enum logic [2:0] {
    RI_TAPCTL  = 3'd0,
    RI_TAPSET  = 3'd1,
    RI_INITPOS = 3'd2,
    RI_CLKSEL  = 3'd3,
    RI_RTCTL   = 3'd4,
    RI_RTREQ   = 3'd5
  } reg_idx_e;

  localparam int TAPNUM_LSB = 16;
  localparam int TAPNUM_W   = 8;
  localparam int ERRFLAG_BIT = 2;
endpackage

// File: rtl/sccr_addr_dec.sv
module sccr_addr_dec
  import sccr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BUS_SHIFT = 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam int LOW_W = BUS_SHIFT + 1;
  localparam int IDX_W = ADDR_W - LOW_W;

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr_i[LOW_W-1:0] == '0);
  assign idx     = addr_i[ADDR_W-1:LOW_W];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel_o[k] = aligned && (idx == IDX_W'(k));
  end

  always_comb begin
    p_sel_onehot_r2: assert ($onehot0(sel_o));
  end
endmodule

// File: rtl/sccr_retune_status.sv
module sccr_retune_status (
  input  logic clk,
  input  logic rst,
  input  logic err_pulse_i,
  input  logic req_wr_i,
  input  logic req_keep_i,
  input  logic en_next_i,
  output logic flag_o,
  output logic err_o
);
  logic flag_d;

  assign flag_d = err_pulse_i | (flag_o & ~(req_wr_i & ~req_keep_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      err_o  <= flag_d & en_next_i;
    end
  end

  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    err_pulse_i |=> flag_o);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (req_wr_i && !req_keep_i && !err_pulse_i) |=> !flag_o);
endmodule

// File: rtl/sccr_rd_mux.sv
module sccr_rd_mux
  import sccr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TAP_W    = 3,
  parameter int NUM_TAPS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_i,
  input  logic [NUM_REGS-1:0] sel_i,
  input  logic                tap_en_i,
  input  logic [TAP_W-1:0]    tap_set_i,
  input  logic [TAP_W-1:0]    init_pos_i,
  input  logic                clk_sel_i,
  input  logic                rt_en_i,
  input  logic                flag_i,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (sel_i[RI_TAPCTL]) begin
      rd_val[0] = tap_en_i;
      rd_val[TAPNUM_LSB +: TAPNUM_W] = TAPNUM_W'(NUM_TAPS);
    end
    if (sel_i[RI_TAPSET])  rd_val[TAP_W-1:0] = tap_set_i;
    if (sel_i[RI_INITPOS]) rd_val[TAP_W-1:0] = init_pos_i;
    if (sel_i[RI_CLKSEL])  rd_val[0] = clk_sel_i;
    if (sel_i[RI_RTCTL])   rd_val[0] = rt_en_i;
    if (sel_i[RI_RTREQ])   rd_val[ERRFLAG_BIT] = flag_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  p_tapnum_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_i && sel_i[RI_TAPCTL]) |=> rdata_o[TAPNUM_LSB +: TAPNUM_W] == TAPNUM_W'(NUM_TAPS));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/sd_sampling_ctrl_regs.sv
module sd_sampling_ctrl_regs
  import sccr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BUS_SHIFT = 1,
  parameter int NUM_TAPS  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic                      retune_err_pulse_i,
  output logic                      tap_en_o,
  output logic [$clog2(NUM_TAPS)-1:0] tap_sel_o,
  output logic [$clog2(NUM_TAPS)-1:0] init_tap_o,
  output logic                      samp_clk_sel_o,
  output logic                      retune_err_o
);
  localparam int TAP_W = $clog2(NUM_TAPS);

  logic [NUM_REGS-1:0] sel;
  logic                rt_en_q;
  logic                rt_en_d;
  logic                err_flag;
  logic                unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:TAP_W];

  sccr_addr_dec #(.ADDR_W(ADDR_W), .BUS_SHIFT(BUS_SHIFT)) dec_i (
    .addr_i (bus_addr),
    .sel_o  (sel)
  );

  assign rt_en_d = (bus_wr && sel[RI_RTCTL]) ? bus_wdata[0] : rt_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_en_o       <= 1'b0;
      tap_sel_o      <= '0;
      init_tap_o     <= '0;
      samp_clk_sel_o <= 1'b0;
      rt_en_q        <= 1'b0;
    end else begin
      rt_en_q <= rt_en_d;
      if (bus_wr) begin
        if (sel[RI_TAPCTL])  tap_en_o       <= bus_wdata[0];
        if (sel[RI_TAPSET])  tap_sel_o      <= bus_wdata[TAP_W-1:0];
        if (sel[RI_INITPOS]) init_tap_o     <= bus_wdata[TAP_W-1:0];
        if (sel[RI_CLKSEL])  samp_clk_sel_o <= bus_wdata[0];
      end
    end
  end

  sccr_retune_status status_i (
    .clk         (clk),
    .rst         (rst),
    .err_pulse_i (retune_err_pulse_i),
    .req_wr_i    (bus_wr && sel[RI_RTREQ]),
    .req_keep_i  (bus_wdata[ERRFLAG_BIT]),
    .en_next_i   (rt_en_d),
    .flag_o      (err_flag),
    .err_o       (retune_err_o)
  );

  sccr_rd_mux #(.DATA_W(DATA_W), .TAP_W(TAP_W), .NUM_TAPS(NUM_TAPS)) rdmux_i (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (bus_rd),
    .sel_i      (sel),
    .tap_en_i   (tap_en_o),
    .tap_set_i  (tap_sel_o),
    .init_pos_i (init_tap_o),
    .clk_sel_i  (samp_clk_sel_o),
    .rt_en_i    (rt_en_q),
    .flag_i     (err_flag),
    .rdata_o    (bus_rdata)
  );

  p_tapset_next_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel[RI_TAPSET]) |=> tap_sel_o == $past(bus_wdata[TAP_W-1:0]));
  p_err_gated_r9: assert property (@(posedge clk) disable iff (rst)
    retune_err_o |-> (rt_en_q && err_flag));
  p_err_reported_r9: assert property (@(posedge clk) disable iff (rst)
    (rt_en_q && err_flag) |-> retune_err_o);
endmodule

// File: tb/sd_sampling_ctrl_regs_tb_top.sv
module sd_sampling_ctrl_regs_tb_top;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int BS = 1;
  localparam int NT = 8;
  localparam int TW = $clog2(NT);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, pulse = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic tap_en_o, samp_clk_sel_o, retune_err_o;
  logic [TW-1:0] tap_sel_o, init_tap_o;

  int vectors = 0, fails = 0, cycles = 0;

  // model state
  logic m_tapen = 0, m_csel = 0, m_ren = 0, m_flag = 0;
  logic [TW-1:0] m_tapset = '0, m_init = '0;

  always #2 clk = ~clk;

  sd_sampling_ctrl_regs #(.ADDR_W(AW), .DATA_W(DW), .BUS_SHIFT(BS), .NUM_TAPS(NT)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .retune_err_pulse_i(pulse),
    .tap_en_o(tap_en_o), .tap_sel_o(tap_sel_o), .init_tap_o(init_tap_o),
    .samp_clk_sel_o(samp_clk_sel_o), .retune_err_o(retune_err_o));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int addr_of(input int k);
    return (2 * k) << BS;
  endfunction

  function automatic int idx_of(input int a);
    if ((a & ((1 << (BS + 1)) - 1)) != 0) return -1;
    if ((a >> (BS + 1)) >= 6) return -1;
    return a >> (BS + 1);
  endfunction

  function automatic logic [DW-1:0] exp_read(input int a);
    logic [DW-1:0] v = '0;
    case (idx_of(a))
      0: begin v[0] = m_tapen; v[23:16] = 8'(NT); end
      1: v[TW-1:0] = m_tapset;
      2: v[TW-1:0] = m_init;
      3: v[0] = m_csel;
      4: v[0] = m_ren;
      5: v[2] = m_flag;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_wr(input int a, input logic [DW-1:0] d);
    case (idx_of(a))
      0: m_tapen = d[0];
      1: m_tapset = d[TW-1:0];
      2: m_init = d[TW-1:0];
      3: m_csel = d[0];
      4: m_ren = d[0];
      5: if (!d[2]) m_flag = 1'b0;
      default: ;
    endcase
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic chk_outs(input string req);
    chk({req, " tap_en R4"}, DW'(tap_en_o), DW'(m_tapen));
    chk({req, " tap_sel R3"}, DW'(tap_sel_o), DW'(m_tapset));
    chk({req, " init_tap R5"}, DW'(init_tap_o), DW'(m_init));
    chk({req, " clk_sel R6"}, DW'(samp_clk_sel_o), DW'(m_csel));
    chk({req, " err_o R9"}, DW'(retune_err_o), DW'(m_flag & m_ren));
  endtask

  task automatic err_pulse();
    @(negedge clk);
    pulse = 1'b1;
    @(negedge clk);
    pulse = 1'b0;
    m_flag = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 rdata", bus_rdata, '0);
    chk_outs("R1");
    for (int k = 0; k < 6; k++) rd(addr_of(k), "R1 readback");

    // R8/R9: flag set with enable off, not reported
    err_pulse();
    chk_outs("R9 enable off");
    rd(addr_of(5), "R8 flag set");
    wr(addr_of(4), 32'h1);            // R7 enable
    chk_outs("R9 enable on");
    rd(addr_of(4), "R7 readback");
    wr(addr_of(5), 32'h4);            // R8 keep
    chk_outs("R8 keep write");
    wr(addr_of(5), 32'h0);            // R8 clear
    chk_outs("R8 clear");
    rd(addr_of(5), "R8 cleared");
    // R8: pulse together with clear keeps flag set
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(addr_of(5)); bus_wdata = 32'h0; pulse = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pulse = 1'b0; m_flag = 1'b1;
    chk_outs("R8 pulse beats clear");
    rd(addr_of(5), "R8 pulse beats clear readback");
    wr(addr_of(4), 32'h0);
    chk_outs("R9 enable dropped");

    // R10: read and write same cycle returns old value, then holds
    wr(addr_of(1), 32'h5);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = AW'(addr_of(1)); bus_wdata = 32'h2;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R10 read before write", bus_rdata, 32'h5);
    model_wr(addr_of(1), 32'h2);
    repeat (3) @(negedge clk);
    chk("R10 hold", bus_rdata, 32'h5);
    chk_outs("R3 after same-cycle write");

    // R2..R7: write every byte address, read all registers back
    for (int a = 0; a < (1 << AW); a++) begin
      logic [DW-1:0] d;
      d = {8'(a) ^ 8'hA5, 8'hFF, 8'(a * 7), 8'(a) ^ 8'h3C};
      if (idx_of(a) == 5) d[2] = 1'b1;  // keep flag so the R8 sticky case is visited
      wr(a, d);
      chk_outs("R2 sweep");
      rd(a, "R2 swept address");
      for (int k = 0; k < 6; k++) rd(addr_of(k), "R2 R4 sweep readback");
    end

    // final clear of flag
    wr(addr_of(5), 32'h0);
    rd(addr_of(5), "R8 final clear");
    chk_outs("R8 final");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule